// File: doc/BRIEF.md
# Extended-Dividend Saturating Divider

This block divides a double-width dividend by a single-width divisor over many clock cycles and returns a single-width quotient, clamped when it does not fit. The dividend is built from two sources. A separate high-word value supplies the upper half. The low half of the first operand supplies the lower half. Any bits of the first operand above the low word are ignored. The quotient sits in a double-width destination: it is zero-extended in unsigned mode and sign-extended in signed mode.

A request is one cycle of `start` while the divider is idle. With it come the mode select, the flag-update select, the high word and both operands. The divider then runs one restoring shift-subtract step per clock and ends with a one-cycle `done` pulse. That pulse carries the result-write strobe, the flag-update strobe with the overflow and carry flags, and the division-by-zero fault.

In signed mode the divider works on magnitudes. It negates the quotient when the dividend and divisor signs differ, so division truncates toward zero.

Top module: `xdiv_sat`

## Requirements
- R1: The dividend is `{hi_word, opa[W-1:0]}`. The bits `opa[2W-1:W]` have no effect on any output.
- R2: In unsigned mode (`is_signed`=0), when the quotient is below 2^W, `result` is the quotient zero-extended to 2W bits.
- R3: In unsigned mode, when the quotient is 2^W or larger, `result` is forced to W zeros followed by W ones (0x00000000FFFFFFFF for W=32).
- R4: In signed mode (`is_signed`=1), the quotient truncates toward zero. When it lies in [-2^(W-1), 2^(W-1)-1], `result` is that quotient sign-extended to 2W bits.
- R5: In signed mode, a positive quotient above 2^(W-1)-1 forces `result` to 2^(W-1)-1 zero-extended (0x7FFFFFFF for W=32). This includes the case of the most negative dividend divided by -1.
- R6: In signed mode, a negative quotient below -2^(W-1) forces `result` to -2^(W-1) sign-extended (0xFFFFFFFF80000000 for W=32).
- R7: A zero divisor gives `done` one cycle after the request is accepted. In that cycle `dz_fault`=1, `res_wr`=0 and `flg_wr`=0, and `result` keeps its previous value.
- R8: When `set_cc`=1 and the divisor is nonzero, `flg_wr` pulses with `done`. In that cycle `flg_ovf` is 1 exactly when R3, R5 or R6 clamped the result, and `flg_carry` is 0. When `set_cc`=0, `flg_wr` and `flg_ovf` stay 0.
- R9: For a nonzero divisor, `done` rises exactly 2W+1 clock edges after the accepting edge and lasts one cycle. `busy` is high from the accepting edge until `done` rises, and it falls in the same cycle.
- R10: A `start` while `busy` is high is ignored. The running division keeps its operands, mode and latency.
- R11: After reset, `busy`, `done`, `res_wr`, `dz_fault`, `flg_wr` and `flg_ovf` are 0, and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division; taken only when idle |
| is_signed | input | 1 | 1 = signed division, 0 = unsigned |
| set_cc | input | 1 | 1 = update flags on completion |
| hi_word | input | W | Upper half of the dividend |
| opa | input | 2W | First operand; only the low W bits are used |
| opb | input | W | Divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| res_wr | output | 1 | With `done`: `result` is valid to write |
| result | output | 2W | Clamped quotient, extended to 2W bits |
| dz_fault | output | 1 | With `done`: divisor was zero |
| flg_wr | output | 1 | With `done`: flags are to be written |
| flg_ovf | output | 1 | Overflow flag: quotient was clamped |
| flg_carry | output | 1 | Carry flag, always 0 |

## Verification
The bench sweeps every divisor value of an 8-bit configuration against a dozen dividends chosen around the clamp edges, in both modes. That covers exact limits such as -128 and 127 next to their first out-of-range neighbours, and the most negative dividend divided by -1.

Each error would show up differently:
- A divider that took its sign from the wrong operand, or clamped at the wrong limit, would return the wrong clamp constant or pass through wrapped quotient bits.
- One that read the upper operand bits would change its result when only those bits change.
- A zero-divisor path that wrote the destination would overwrite the previous result.
- One that accepted a request while busy would finish early or with the wrong operands.

// File: rtl/xdiv_pkg.sv
package xdiv_pkg;
  typedef enum logic [1:0] {
    XD_IDLE = 2'd0,
    XD_RUN  = 2'd1,
    XD_FIN  = 2'd2
  } xd_state_e;
endpackage

// File: rtl/xdiv_prep.sv
module xdiv_prep #(
  parameter int W = 32
) (
  input  logic           is_signed,
  input  logic [W-1:0]   hi,
  input  logic [W-1:0]   lo,
  input  logic [W-1:0]   dvs,
  output logic [2*W-1:0] num_mag,
  output logic [W-1:0]   den_mag,
  output logic           neg,
  output logic           den_zero
);
  localparam int W2 = 2 * W;

  // magnitude of a two's complement value when signed handling is on
  function automatic logic [W2-1:0] mag_wide(input logic [W2-1:0] v, input logic s);
    return (s && v[W2-1]) ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [W-1:0] mag_narrow(input logic [W-1:0] v, input logic s);
    return (s && v[W-1]) ? (~v + 1'b1) : v;
  endfunction

  logic [W2-1:0] num;

  always_comb begin
    num      = {hi, lo};
    num_mag  = mag_wide(num, is_signed);
    den_mag  = mag_narrow(dvs, is_signed);
    neg      = is_signed & (num[W2-1] ^ dvs[W-1]);
    den_zero = (dvs == '0);
  end
endmodule

// File: rtl/xdiv_core.sv
module xdiv_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [2*W-1:0] num,
  input  logic [W-1:0]   den,
  output logic [2*W-1:0] quo
);
  localparam int W2 = 2 * W;

  logic [W-1:0]  rem_q;
  logic [W-1:0]  den_q;
  logic [W2-1:0] quo_q;
  logic [W:0]    trial;
  logic          fits;
  logic [W-1:0]  rem_next;

  // one restoring step: shift the next dividend bit in, subtract if it fits
  function automatic logic [W:0] restore_step(input logic [W:0] t, input logic [W-1:0] d);
    logic [W:0] dd;
    dd = {1'b0, d};
    if (t >= dd) return {1'b1, W'(t - dd)};
    return {1'b0, t[W-1:0]};
  endfunction

  always_comb begin
    trial              = {rem_q, quo_q[W2-1]};
    {fits, rem_next}   = restore_step(trial, den_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      den_q <= '0;
      quo_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      den_q <= den;
      quo_q <= num;
    end else if (step) begin
      rem_q <= rem_next;
      quo_q <= {quo_q[W2-2:0], fits};
    end
  end

  assign quo = quo_q;

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (rem_q < den_q)); // R2
endmodule

// File: rtl/xdiv_clamp.sv
module xdiv_clamp #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] qmag,
  input  logic           neg,
  input  logic           sgn,
  output logic [2*W-1:0] res,
  output logic           sat
);
  localparam int W2 = 2 * W;
  localparam logic [W2-1:0] CLAMP_U = {{W{1'b0}}, {W{1'b1}}};
  localparam logic [W2-1:0] CLAMP_P = {{(W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic [W2-1:0] CLAMP_N = {{(W+1){1'b1}}, {(W-1){1'b0}}};
  localparam logic [W2-1:0] LIM_P   = CLAMP_P;
  localparam logic [W2-1:0] LIM_N   = CLAMP_P + 1'b1;

  // returns {saturated, value}
  function automatic logic [W2:0] clamp_q(input logic [W2-1:0] q, input logic n, input logic s);
    logic hit;
    if (!s) begin
      hit = |q[W2-1:W];
      return {hit, hit ? CLAMP_U : q};
    end
    if (!n) begin
      hit = q > LIM_P;
      return {hit, hit ? CLAMP_P : q};
    end
    hit = q > LIM_N;
    return {hit, hit ? CLAMP_N : (~q + 1'b1)};
  endfunction

  always_comb {sat, res} = clamp_q(qmag, neg, sgn);
endmodule

// File: rtl/xdiv_sat.sv
module xdiv_sat
  import xdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           is_signed,
  input  logic           set_cc,
  input  logic [W-1:0]   hi_word,
  input  logic [2*W-1:0] opa,
  input  logic [W-1:0]   opb,
  output logic           busy,
  output logic           done,
  output logic           res_wr,
  output logic [2*W-1:0] result,
  output logic           dz_fault,
  output logic           flg_wr,
  output logic           flg_ovf,
  output logic           flg_carry
);
  localparam int W2    = 2 * W;
  localparam int ITER  = W2;
  localparam int CNT_W = $clog2(ITER);
  localparam logic [W2-1:0] CLAMP_U = {{W{1'b0}}, {W{1'b1}}};
  localparam logic [W2-1:0] CLAMP_P = {{(W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic [W2-1:0] CLAMP_N = {{(W+1){1'b1}}, {(W-1){1'b0}}};

  xd_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic            mode_sgn, mode_cc, neg_q, dz_q;

  logic [W2-1:0]   num_mag;
  logic [W-1:0]    den_mag;
  logic            neg, den_zero;
  logic [W2-1:0]   quo;
  logic [W2-1:0]   clamp_res;
  logic            clamp_hit;

  // named internal events
  logic accept, run_step, last_iter, finishing;
  logic unused_opa_hi;

  assign accept        = (st == XD_IDLE) && start;
  assign run_step      = (st == XD_RUN);
  assign last_iter     = run_step && (cnt == CNT_W'(ITER - 1));
  assign finishing     = (st == XD_FIN);
  assign busy          = (st != XD_IDLE);
  assign flg_carry     = 1'b0;
  assign unused_opa_hi = ^opa[W2-1:W];

  xdiv_prep #(.W(W)) u_prep (
    .is_signed (is_signed),
    .hi        (hi_word),
    .lo        (opa[W-1:0]),
    .dvs       (opb),
    .num_mag   (num_mag),
    .den_mag   (den_mag),
    .neg       (neg),
    .den_zero  (den_zero)
  );

  xdiv_core #(.W(W)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept && !den_zero),
    .step  (run_step),
    .num   (num_mag),
    .den   (den_mag),
    .quo   (quo)
  );

  xdiv_clamp #(.W(W)) u_clamp (
    .qmag (quo),
    .neg  (neg_q),
    .sgn  (mode_sgn),
    .res  (clamp_res),
    .sat  (clamp_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= XD_IDLE;
      cnt      <= '0;
      mode_sgn <= 1'b0;
      mode_cc  <= 1'b0;
      neg_q    <= 1'b0;
      dz_q     <= 1'b0;
      done     <= 1'b0;
      res_wr   <= 1'b0;
      dz_fault <= 1'b0;
      flg_wr   <= 1'b0;
      flg_ovf  <= 1'b0;
      result   <= '0;
    end else begin
      done     <= 1'b0;
      res_wr   <= 1'b0;
      dz_fault <= 1'b0;
      flg_wr   <= 1'b0;
      flg_ovf  <= 1'b0;
      unique case (st)
        XD_IDLE: if (accept) begin
          mode_sgn <= is_signed;
          mode_cc  <= set_cc;
          neg_q    <= neg;
          dz_q     <= den_zero;
          cnt      <= '0;
          st       <= den_zero ? XD_FIN : XD_RUN;
        end
        XD_RUN: begin
          cnt <= cnt + 1'b1;
          if (last_iter) st <= XD_FIN;
        end
        XD_FIN: begin
          done     <= 1'b1;
          dz_fault <= dz_q;
          res_wr   <= !dz_q;
          flg_wr   <= mode_cc && !dz_q;
          flg_ovf  <= mode_cc && !dz_q && clamp_hit;
          if (!dz_q) result <= clamp_res;
          st <= XD_IDLE;
        end
        default: st <= XD_IDLE;
      endcase
    end
  end

  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy)); // R9
  AST_DZ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dz_fault |-> (done && !res_wr && !flg_wr)); // R7
  AST_CLAMP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    flg_ovf |-> (result == CLAMP_U || result == CLAMP_P || result == CLAMP_N)); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(mode_sgn) && $stable(mode_cc) && $stable(neg_q))); // R10
endmodule

// File: tb/xdiv_sat_test.sv
module xdiv_sat_test;
  localparam int W  = 8;
  localparam int W2 = 2 * W;
  localparam int LAT = W2 + 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, start, is_signed, set_cc;
  logic [W-1:0]  hi_word, opb;
  logic [W2-1:0] opa;
  logic          busy, done, res_wr, dz_fault, flg_wr, flg_ovf, flg_carry;
  logic [W2-1:0] result;

  xdiv_sat #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed), .set_cc(set_cc),
    .hi_word(hi_word), .opa(opa), .opb(opb), .busy(busy), .done(done), .res_wr(res_wr),
    .result(result), .dz_fault(dz_fault), .flg_wr(flg_wr), .flg_ovf(flg_ovf),
    .flg_carry(flg_carry)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [W2-1:0] last_res = '0;

  task automatic chk(input string tag, input logic [W2-1:0] act, input logic [W2-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // arithmetic reference
  task automatic model(input bit sgn, input logic [W-1:0] hi, input logic [W-1:0] lo,
                       input logic [W-1:0] b, output logic [W2-1:0] er, output bit esat,
                       output string tag);
    longint d, dv, q, pmax, nmin;
    pmax = (longint'(1) << (W - 1)) - 1;
    nmin = -(longint'(1) << (W - 1));
    if (!sgn) begin
      d = longint'({hi, lo});
      q = d / longint'(b);
      if (q > ((longint'(1) << W) - 1)) begin er = W2'((longint'(1) << W) - 1); esat = 1; tag = "R3"; end
      else begin er = W2'(q); esat = 0; tag = "R2"; end
    end else begin
      d  = longint'($signed({hi, lo}));
      dv = longint'($signed(b));
      q  = d / dv;
      if (q > pmax)      begin er = W2'(pmax); esat = 1; tag = "R5"; end
      else if (q < nmin) begin er = W2'(nmin); esat = 1; tag = "R6"; end
      else               begin er = W2'(q);    esat = 0; tag = "R4"; end
    end
  endtask

  task automatic issue(input bit sgn, input bit cc, input logic [W-1:0] hi,
                       input logic [W-1:0] lo, input logic [W-1:0] upper, input logic [W-1:0] b);
    @(negedge clk);
    start = 1'b1; is_signed = sgn; set_cc = cc; hi_word = hi; opa = {upper, lo}; opb = b;
    @(posedge clk); #2;
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (!done && lat < 100) begin
      @(posedge clk); #2;
      lat++;
    end
  endtask

  task automatic do_vec(input bit sgn, input bit cc, input logic [W-1:0] hi,
                        input logic [W-1:0] lo, input logic [W-1:0] upper, input logic [W-1:0] b);
    logic [W2-1:0] er; bit esat; string tag; int lat;
    if (b != '0) model(sgn, hi, lo, b, er, esat, tag);
    issue(sgn, cc, hi, lo, upper, b);
    wait_done(lat);
    if (b == '0) begin
      chk("R7 latency", W2'(lat), W2'(1));
      chk("R7 dz/res_wr/flg_wr", W2'({dz_fault, res_wr, flg_wr}), W2'(3'b100));
      chk("R7 result kept", result, last_res);
    end else begin
      chk("R9 latency", W2'(lat), W2'(LAT));
      chk("R9 busy falls with done", W2'({done, busy}), W2'(2'b10));
      chk({tag, " result"}, result, er);
      chk("R8 flags {res_wr,dz,flg_wr,ovf,carry}",
          W2'({res_wr, dz_fault, flg_wr, flg_ovf, flg_carry}),
          W2'({1'b1, 1'b0, cc, cc & esat, 1'b0}));
      last_res = er;
    end
  endtask

  function automatic logic [W2-1:0] pattern(input int k);
    case (k)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'h00FF;  3: return 16'h0100;
      4: return 16'h7FFF;  5: return 16'h8000;  6: return 16'hFFFF;  7: return 16'h8001;
      8: return 16'h3A5C;  9: return 16'hC3D2; 10: return 16'h0080;  default: return 16'hFF80;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R9 watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W2-1:0] r_a, er; bit esat; string tag; int lat;
    rst_n = 1'b0; start = 1'b0; is_signed = 1'b0; set_cc = 1'b0;
    hi_word = '0; opa = '0; opb = '0;
    repeat (3) @(posedge clk);
    #2;
    // R11 reset state
    chk("R11 reset outputs", W2'({busy, done, res_wr, dz_fault, flg_wr, flg_ovf}), '0);
    chk("R11 reset result", result, '0);
    @(negedge clk); rst_n = 1'b1;

    // R7 zero divisor right after reset keeps zero result
    do_vec(1'b0, 1'b1, 8'h12, 8'h34, 8'h00, 8'h00);

    // R1 upper operand bits ignored
    do_vec(1'b1, 1'b1, 8'hF3, 8'h21, 8'h00, 8'h07);
    r_a = result;
    do_vec(1'b1, 1'b1, 8'hF3, 8'h21, 8'hFF, 8'h07);
    chk("R1 upper bits no effect", result, r_a);

    // R10 start while busy is ignored
    model(1'b0, 8'h12, 8'h34, 8'h56, er, esat, tag);
    issue(1'b0, 1'b0, 8'h12, 8'h34, 8'h00, 8'h56);
    chk("R9 busy after accept", W2'(busy), W2'(1));
    repeat (2) @(negedge clk);
    start = 1'b1; is_signed = 1'b1; set_cc = 1'b1; hi_word = 8'h80; opa = '0; opb = 8'h00;
    @(negedge clk); start = 1'b0;
    @(posedge clk); #2;
    wait_done(lat);
    chk("R10 latency unchanged", W2'(lat + 3), W2'(LAT));
    chk("R10 result of first request", result, er);
    chk("R10 no fault/flags from ignored start", W2'({res_wr, dz_fault, flg_wr}), W2'(3'b100));
    last_res = er;

    // sweep: every divisor, boundary dividends, both modes
    for (int b = 0; b < 256; b++) begin
      for (int k = 0; k < 12; k++) begin
        for (int s = 0; s < 2; s++) begin
          logic [W2-1:0] d;
          d = pattern(k);
          do_vec(s[0], b[0] ^ k[0], d[W2-1:W], d[W-1:0], W'(b ^ 8'hA5 ^ k), W'(b));
        end
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule